// File: doc/BRIEF.md
# Transmit Abort With FCS Corruption

This block sits on the byte-wide transmit path, between the frame source and the line. Frame bytes arrive on a valid/ready handshake, with start-of-frame and end-of-frame markers. Each accepted byte goes to the line one cycle later, with a transmit-enable signal. On the way, the block runs a CRC-32 frame check sequence and counts the bits already sent. A normal frame ends with its four FCS bytes appended.

An abort request during the data phase ends the frame in one of two ways, depending on how much of it has already left. If fewer than 512 bits are out, the frame is cut at once and becomes a runt. Otherwise the bitwise inverse of the FCS over the bytes sent so far is appended, starting at the next byte slot, so that the receiver is certain to see an FCS error. In both cases a one-cycle done pulse marks the first cycle in which transmit-enable is low again.

Top module: `tx_abort_fcs`

## Requirements
- R1: After reset, line_en_o and abort_done_o are 0 and in_ready_o is 1.
- R2: A byte accepted with in_sof_i while idle, and every later byte accepted in the same frame, appears on line_data_o with line_en_o high in the cycle after the accepting edge, in order.
- R3: After the byte accepted with in_eof_i, the next four byte slots carry the FCS, with no gap. The FCS is CRC-32 with reflected polynomial 0xEDB88320, preset all-ones and final complement, sent least significant byte first (bytes "123456789" give 26 39 F4 CB). line_en_o then drops, and abort_done_o stays low.
- R4: The sent-bit count starts with the start-of-frame byte, adds 8 for each byte accepted and saturates at 512. The abort choice therefore flips between 63 and 64 bytes sent.
- R5: If abort_i is high during the data phase with fewer than 512 bits sent, line_en_o is low from the next cycle. The byte offered in the same cycle is not accepted.
- R6: If abort_i is high during the data phase with 512 or more bits sent, the next four byte slots carry the bitwise inverse of the FCS of the bytes sent, least significant byte first, with no gap.
- R7: abort_done_o is a single-cycle pulse. It is raised only after an aborted frame, in the first cycle in which line_en_o is low.
- R8: abort_i has no effect while idle or during the four-byte FCS tail.
- R9: While idle, bytes offered without in_sof_i are discarded and produce no line output.
- R10: in_ready_o is low during the FCS tail and in any data-phase cycle in which abort_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Source byte valid |
| in_ready_o | output | 1 | Block can take a byte |
| in_data_i | input | 8 | Source byte |
| in_sof_i | input | 1 | Byte is the first of a frame |
| in_eof_i | input | 1 | Byte is the last of a frame |
| abort_i | input | 1 | Abort the frame in progress |
| line_data_o | output | 8 | Byte driven to the line |
| line_en_o | output | 1 | Transmit enable; line_data_o is valid |
| abort_done_o | output | 1 | One-cycle pulse after an aborted frame ends |

## Verification
The main path is exercised with frames of one, nine, twenty and seventy bytes that end normally. It is also exercised with frames aborted after 1, 63, 64 and 100 bytes. The 63/64 pair separates the runt cut from the corrupted-FCS tail at the exact 512-bit boundary. Comparing the tail of an aborted long frame with the true FCS of the same bytes shows whether the inverted value is used. The known nine-byte check string pins the CRC parameters. Aborts raised while idle or during the FCS tail, and idle bytes without a start marker, show that those inputs leave the line untouched.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;
  localparam int BYTE_W    = 8;
  localparam int CRC_W     = 32;
  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_TAIL} tx_state_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction
endpackage

// File: rtl/tx_bit_meter.sv
module tx_bit_meter #(
  parameter int LIMIT  = 512,
  parameter int STEP   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_i,
  output logic reached_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;

  assign sum = {1'b0, cnt_q} + (CW+1)'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(STEP);
    else if (step_i) cnt_q <= (sum >= (CW+1)'(LIMIT)) ? CW'(LIMIT) : sum[CW-1:0];
  end

  assign reached_o = (cnt_q >= CW'(LIMIT));

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT)); // R4
endmodule

// File: rtl/tx_fcs_crc.sv
module tx_fcs_crc
  import tx_abort_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else if (start_i) crc_q <= crc_step('1, data_i);
    else if (step_i) crc_q <= crc_step(crc_q, data_i);
  end

  assign crc_o = crc_q;

  AST_CRC_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !step_i) |=> $stable(crc_o)); // R3
endmodule

// File: rtl/tx_abort_fcs.sv
module tx_abort_fcs
  import tx_abort_pkg::*;
#(
  parameter int RUNT_BITS = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              abort_i,
  output logic [BYTE_W-1:0] line_data_o,
  output logic              line_en_o,
  output logic              abort_done_o
);
  localparam int IW = $clog2(FCS_BYTES + 1);

  tx_state_e        state_q;
  logic [IW-1:0]    idx_q;
  logic             bad_q;
  logic [CRC_W-1:0] crc;
  logic             reached;
  logic             sof_take, byte_take;
  logic [CRC_W-1:0] tail_word;
  logic [BYTE_W-1:0] tail_byte;

  assign in_ready_o = (state_q == ST_IDLE) || (state_q == ST_DATA && !abort_i);
  assign sof_take   = (state_q == ST_IDLE) && in_valid_i && in_sof_i;
  assign byte_take  = (state_q == ST_DATA) && in_valid_i && !abort_i;

  tx_fcs_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sof_take),
    .step_i (byte_take),
    .data_i (in_data_i),
    .crc_o  (crc)
  );

  tx_bit_meter #(.LIMIT(RUNT_BITS), .STEP(BYTE_W)) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (sof_take),
    .step_i   (byte_take),
    .reached_o(reached)
  );

  // good FCS is the complemented register; a corrupted one is the raw register
  assign tail_word = bad_q ? crc : ~crc;
  assign tail_byte = tail_word[idx_q[IW-2:0]*BYTE_W +: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      bad_q        <= 1'b0;
      line_data_o  <= '0;
      line_en_o    <= 1'b0;
      abort_done_o <= 1'b0;
    end else begin
      abort_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          line_en_o <= 1'b0;
          if (sof_take) begin
            line_data_o <= in_data_i;
            line_en_o   <= 1'b1;
            idx_q       <= '0;
            bad_q       <= 1'b0;
            state_q     <= in_eof_i ? ST_TAIL : ST_DATA;
          end
        end
        ST_DATA: begin
          if (abort_i) begin
            if (reached) begin
              line_data_o <= crc[BYTE_W-1:0];
              line_en_o   <= 1'b1;
              bad_q       <= 1'b1;
              idx_q       <= IW'(1);
              state_q     <= ST_TAIL;
            end else begin
              line_en_o    <= 1'b0;
              abort_done_o <= 1'b1;
              state_q      <= ST_IDLE;
            end
          end else if (byte_take) begin
            line_data_o <= in_data_i;
            line_en_o   <= 1'b1;
            if (in_eof_i) begin
              idx_q   <= '0;
              bad_q   <= 1'b0;
              state_q <= ST_TAIL;
            end
          end else begin
            line_en_o <= 1'b0;
          end
        end
        ST_TAIL: begin
          if (idx_q == IW'(FCS_BYTES)) begin
            line_en_o    <= 1'b0;
            abort_done_o <= bad_q;
            state_q      <= ST_IDLE;
          end else begin
            line_data_o <= tail_byte;
            line_en_o   <= 1'b1;
            idx_q       <= idx_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_done_o |=> !abort_done_o); // R7
  AST_DONE_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_done_o |-> !line_en_o); // R7
  AST_RUNT_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && abort_i && !reached) |=> (!line_en_o && abort_done_o)); // R5
  AST_BAD_FCS_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && abort_i && reached) |=> (line_en_o && !abort_done_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !(in_valid_i && in_sof_i)) |=> (!line_en_o && !abort_done_o)); // R9
  AST_TAIL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL) |-> !in_ready_o); // R10
endmodule

// File: tb/tx_abort_fcs_test.sv
`timescale 1ns/1ps
module tx_abort_fcs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, abort = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, line_en, abort_done;
  logic [7:0] line_data;

  int n_tests = 0, n_fail = 0;
  logic [7:0] fb [256];
  logic [7:0] cap [512];
  int ncap = 0, ndone = 0, done_bad = 0;
  logic prev_en = 1'b0;

  always #2.5 clk = ~clk;

  tx_abort_fcs uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_sof_i(in_sof), .in_eof_i(in_eof), .abort_i(abort),
    .line_data_o(line_data), .line_en_o(line_en), .abort_done_o(abort_done)
  );

  always @(negedge clk) begin
    if (line_en && ncap < 512) begin cap[ncap] = line_data; ncap++; end
    if (abort_done) begin
      ndone++;
      if (!prev_en || line_en) done_bad++;
    end
    prev_en = line_en;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ fb[i][b]) c = (c >> 1) ^ 32'hEDB8_8320;
        else c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic drive_idle();
    in_valid = 0; in_sof = 0; in_eof = 0; abort = 0;
  endtask

  task automatic send_frame(input int len, input int abort_at, input bit tail_abort);
    ncap = 0; ndone = 0; done_bad = 0;
    @(posedge clk); #1;
    for (int j = 0; j < len; j++) begin
      if (abort_at != 0 && j == abort_at) begin
        in_valid = 1; in_data = fb[j]; in_sof = 0; in_eof = 0; abort = 1;
        @(negedge clk);
        chk(!in_ready, "R10 abort blocks ready", in_ready, 0);
        @(posedge clk); #1;
        break;
      end
      in_valid = 1; in_data = fb[j]; in_sof = (j == 0); in_eof = (j == len - 1); abort = 0;
      forever begin
        @(negedge clk);
        if (in_ready) break;
        @(posedge clk); #1;
      end
      @(posedge clk); #1;
    end
    drive_idle();
    if (tail_abort) begin
      abort = 1;
      for (int t = 0; t < 3; t++) begin
        @(negedge clk);
        chk(!in_ready, "R10 tail ready", in_ready, 0);
        @(posedge clk); #1;
      end
      abort = 0;
    end
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic check_frame(input int len, input int abort_at, input string tag);
    int k, nexp, mism;
    logic [31:0] c, w;
    bit ab;
    ab = (abort_at != 0);
    k = ab ? abort_at : len;
    c = ref_crc(k);
    nexp = k;
    if (!ab) begin w = ~c; nexp = k + 4; end
    else if (k * 8 >= 512) begin w = c; nexp = k + 4; end
    else w = '0;
    chk(ncap == nexp, {tag, " length"}, ncap, nexp);
    mism = 0;
    for (int i = 0; i < k && i < ncap; i++) if (cap[i] !== fb[i]) mism++;
    chk(mism == 0, "R2 payload bytes", mism, 0);
    if (nexp == k + 4 && ncap == nexp)
      for (int i = 0; i < 4; i++)
        chk(cap[k+i] === w[i*8 +: 8], {tag, " fcs byte"}, cap[k+i], w[i*8 +: 8]);
    chk(ndone == (ab ? 1 : 0), "R7 done count", ndone, ab ? 1 : 0);
    chk(done_bad == 0, "R7 done timing", done_bad, 0);
  endtask

  localparam int NV = 7;
  localparam int V_LEN [NV] = '{20, 1, 70, 40, 80, 80, 150};
  localparam int V_ABT [NV] = '{ 0, 0,  0,  1, 63, 64, 100};

  initial begin
    drive_idle();
    repeat (3) @(posedge clk);
    #1;
    chk(!line_en && !abort_done && in_ready, "R1 reset state",
        {line_en, abort_done, in_ready}, 3'b001);
    rst_n = 1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      for (int i = 0; i < 256; i++) fb[i] = 8'(v * 31 + i * 13 + 5);
      send_frame(V_LEN[v], V_ABT[v], 1'b0);
      if (V_ABT[v] == 0) tag = "R3";
      else if (V_ABT[v] * 8 < 512) tag = "R5/R4 runt";
      else tag = "R6/R4 inverted";
      check_frame(V_LEN[v], V_ABT[v], tag);
    end

    // known check string
    for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
    send_frame(9, 0, 1'b0);
    chk(ncap == 13, "R3 check string length", ncap, 13);
    chk({cap[12], cap[11], cap[10], cap[9]} == 32'hCBF43926, "R3 check string fcs",
        {cap[12], cap[11], cap[10], cap[9]}, 32'hCBF43926);

    // abort during tail has no effect
    for (int i = 0; i < 256; i++) fb[i] = 8'(i * 3);
    send_frame(10, 0, 1'b1);
    check_frame(10, 0, "R8 tail abort");

    // abort while idle
    ncap = 0; ndone = 0;
    @(posedge clk); #1;
    abort = 1;
    repeat (3) @(posedge clk);
    #1; abort = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(ncap == 0 && ndone == 0, "R8 idle abort", ncap + ndone, 0);

    // bytes without start marker while idle
    ncap = 0;
    in_valid = 1; in_data = 8'hA5; in_sof = 0;
    repeat (4) @(posedge clk);
    #1; drive_idle();
    repeat (3) @(posedge clk);
    #1;
    chk(ncap == 0, "R9 non-sof discarded", ncap, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule